// File: doc/BRIEF.md
# Coalescing Unordered Write Cache

This block is a per-core store buffer organized as a small set-associative cache of whole lines. While a stratum executes, it takes stores from the core without keeping their program order. A store to a line already held merges into that entry: its byte mask is ORed in and only the selected bytes are overwritten. Loads from the core look the buffer up first. Each byte the buffer holds replaces the corresponding byte of the downstream data that comes with the load.

When the stratum ends, a flush command starts the publish phase. The block walks its entries in index order and hands every valid entry to the memory side. It then clears itself and pulses a done flag, so that the whole stratum's writes become visible as one unit. A store that finds its set full is never handled by eviction. In bounded mode the store is held back and an overflow request asks for the stratum to end. In unbounded mode the store is diverted to a log channel and execution continues.

Store, load, drain and log traffic use valid/ready handshakes. A store or load is taken on a rising clock edge where both valid and ready are high. While publishing, ready stays low on both. A drain beat or log record is taken when the receiver's ready is high. A drain beat that is not taken holds its line, data and mask unchanged. The mode, flush command, publish, done and overflow pins are plain levels or pulses.

Top module: `stratum_wcache`

## Requirements
- R1: After reset the buffer is empty: publish, flush_done, overflow_req, log_valid and dr_valid are low, and st_ready and ld_ready are high.
- R2: A store to a line that is not held allocates the lowest-numbered free way of set `line[SET_W-1:0]`. Entry index is `set*WAYS + way`, and drain beats come out in ascending entry index.
- R3: A store to a line already held uses no new entry. The entry mask becomes old mask OR store mask, and only the bytes whose store mask bit is 1 take new data (bit b covers data bits `8b+7:8b`).
- R4: A load taken at edge E gives ld_rsp_valid for one cycle after E. Each response byte is the buffered byte if the line is held and its mask bit is set, otherwise the ld_mem_data byte. ld_rsp_full is 1 exactly when every byte set in ld_mask is buffered.
- R5: While publish is high, st_ready and ld_ready are low.
- R6: A flush_start sampled while idle raises publish on the next cycle. Each valid entry then gives one drain beat with its line, data and mask. A beat held by a low dr_ready keeps its values.
- R7: flush_done is a one-cycle pulse in the first cycle publish is low again. Afterwards the buffer is empty, so a further flush gives no beats.
- R8: In bounded mode (mode_bounded=1), a store that misses a full set is not taken: st_ready is low and overflow_req is high while it is offered, and the buffer is unchanged. After a flush the same store is taken.
- R9: In unbounded mode (mode_bounded=0), a store that misses a full set is offered on the log channel. It is taken when log_ready is high, it does not enter the buffer, and overflow_req stays low.
- R10: A flush_start while publish is high is ignored: it starts no second flush.
- R11: Geometry is parameterized (ENTRIES, WAYS, LINE_BYTES; 64/8/64 by default, with 32 and 16 entries supported). With no drain stalls, publish stays high for exactly ENTRIES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bounded | input | 1 | 1: full-set miss requests stratum end; 0: full-set miss goes to log |
| flush_start | input | 1 | Starts the publish phase when idle |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken |
| st_line | input | LINE_AW | Store line address |
| st_data | input | LINE_BYTES*8 | Store line data |
| st_mask | input | LINE_BYTES | Store byte enables |
| ld_valid | input | 1 | Load lookup offered |
| ld_ready | output | 1 | Load can be taken |
| ld_line | input | LINE_AW | Load line address |
| ld_mask | input | LINE_BYTES | Bytes the load needs |
| ld_mem_data | input | LINE_BYTES*8 | Downstream line data for the load |
| ld_rsp_valid | output | 1 | Load response valid |
| ld_rsp_data | output | LINE_BYTES*8 | Merged load data |
| ld_rsp_full | output | 1 | All needed bytes came from the buffer |
| dr_valid | output | 1 | Drain beat valid |
| dr_ready | input | 1 | Memory side takes drain beat |
| dr_line | output | LINE_AW | Drained line address |
| dr_data | output | LINE_BYTES*8 | Drained data |
| dr_mask | output | LINE_BYTES | Drained byte mask |
| log_valid | output | 1 | Overflowing store offered to log |
| log_ready | input | 1 | Log takes the store |
| log_line | output | LINE_AW | Logged line address |
| log_data | output | LINE_BYTES*8 | Logged data |
| log_mask | output | LINE_BYTES | Logged byte mask |
| publish | output | 1 | Publish phase active |
| flush_done | output | 1 | One-cycle pulse at end of flush |
| overflow_req | output | 1 | Bounded-mode stratum-end request |

## Verification
The buffer is filled with three lines in every set, each with a different byte mask. Every line is then stored again with an overlapping mask. This separates merging from fresh allocation, and a wrong OR or byte select shows up in the drained masks and data. Loads are swept over every held line and one absent line per set, with full, partial and single-byte masks, so that full forwarding, partial merging and misses can each be told apart. Flushes run with a periodic drain stall and a stray flush command. One set is filled completely in each mode to show the difference between the held-store overflow request and the diverted log record.

// File: rtl/stratum_wcache_pkg.sv
package stratum_wcache_pkg;
  typedef enum logic {
    OVF_LOG  = 1'b0,
    OVF_HALT = 1'b1
  } ovf_mode_e;
endpackage

// File: rtl/wc_set_probe.sv
module wc_set_probe #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way
);
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_valid[w] && way_tag[w] == tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!way_valid[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/wc_flush_seq.sv
module wc_flush_seq #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cur_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic             done,
  output logic             clear_all
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic step;
  assign step      = busy && (!cur_valid || out_ready);
  assign clear_all = step && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          ptr  <= '0;
        end
      end else if (step) begin
        if (ptr == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stratum_wcache.sv
module stratum_wcache
  import stratum_wcache_pkg::*;
#(
  parameter int unsigned ENTRIES    = 64,
  parameter int unsigned WAYS       = 8,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned LINE_AW    = 26,
  localparam int unsigned SETS  = ENTRIES / WAYS,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned IDX_W = $clog2(ENTRIES),
  localparam int unsigned TAG_W = LINE_AW - SET_W,
  localparam int unsigned DW    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_bounded,
  input  logic                  flush_start,
  input  logic                  st_valid,
  output logic                  st_ready,
  input  logic [LINE_AW-1:0]    st_line,
  input  logic [DW-1:0]         st_data,
  input  logic [LINE_BYTES-1:0] st_mask,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [LINE_AW-1:0]    ld_line,
  input  logic [LINE_BYTES-1:0] ld_mask,
  input  logic [DW-1:0]         ld_mem_data,
  output logic                  ld_rsp_valid,
  output logic [DW-1:0]         ld_rsp_data,
  output logic                  ld_rsp_full,
  output logic                  dr_valid,
  input  logic                  dr_ready,
  output logic [LINE_AW-1:0]    dr_line,
  output logic [DW-1:0]         dr_data,
  output logic [LINE_BYTES-1:0] dr_mask,
  output logic                  log_valid,
  input  logic                  log_ready,
  output logic [LINE_AW-1:0]    log_line,
  output logic [DW-1:0]         log_data,
  output logic [LINE_BYTES-1:0] log_mask,
  output logic                  publish,
  output logic                  flush_done,
  output logic                  overflow_req
);
  // entry storage
  logic [ENTRIES-1:0]    v_q;
  logic [TAG_W-1:0]      tag_q  [ENTRIES];
  logic [DW-1:0]         data_q [ENTRIES];
  logic [LINE_BYTES-1:0] mask_q [ENTRIES];

  ovf_mode_e mode;
  assign mode = ovf_mode_e'(mode_bounded);

  // address split
  logic [SET_W-1:0] st_set, ld_set;
  logic [TAG_W-1:0] st_tag, ld_tag;
  assign st_set = st_line[SET_W-1:0];
  assign st_tag = st_line[LINE_AW-1:SET_W];
  assign ld_set = ld_line[SET_W-1:0];
  assign ld_tag = ld_line[LINE_AW-1:SET_W];

  // gather the ways of the addressed sets
  logic [WAYS-1:0]            st_wv, ld_wv;
  logic [WAYS-1:0][TAG_W-1:0] st_wt, ld_wt;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [IDX_W-1:0] st_i, ld_i;
    assign st_i     = {st_set, WAY_W'(w)};
    assign ld_i     = {ld_set, WAY_W'(w)};
    assign st_wv[w] = v_q[st_i];
    assign st_wt[w] = tag_q[st_i];
    assign ld_wv[w] = v_q[ld_i];
    assign ld_wt[w] = tag_q[ld_i];
  end

  logic             st_hit, st_free, ld_hit, ld_free;
  logic [WAY_W-1:0] st_hit_way, st_free_way, ld_hit_way, ld_free_way;

  wc_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_st_probe (
    .way_valid(st_wv), .way_tag(st_wt), .tag(st_tag),
    .hit(st_hit), .hit_way(st_hit_way),
    .has_free(st_free), .free_way(st_free_way)
  );

  wc_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ld_probe (
    .way_valid(ld_wv), .way_tag(ld_wt), .tag(ld_tag),
    .hit(ld_hit), .hit_way(ld_hit_way),
    .has_free(ld_free), .free_way(ld_free_way)
  );

  // flush sequencing
  logic             busy, clear_all;
  logic [IDX_W-1:0] ptr;

  wc_flush_seq #(.ENTRIES(ENTRIES)) u_flush (
    .clk(clk), .rst_n(rst_n), .start(flush_start),
    .cur_valid(v_q[ptr]), .out_ready(dr_ready),
    .busy(busy), .ptr(ptr), .done(flush_done), .clear_all(clear_all)
  );

  // store acceptance and overflow routing
  logic st_room, st_spill, st_write;
  logic [IDX_W-1:0] st_idx;
  assign st_room  = st_hit || st_free;
  assign st_spill = st_valid && !busy && !st_room;
  assign st_ready = !busy && (st_room || (mode == OVF_LOG && log_ready));
  assign st_write = st_valid && st_ready && st_room;
  assign st_idx   = {st_set, (st_hit ? st_hit_way : st_free_way)};

  assign overflow_req = st_spill && (mode == OVF_HALT);
  assign log_valid    = st_spill && (mode == OVF_LOG);
  assign log_line     = st_line;
  assign log_data     = st_data;
  assign log_mask     = st_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (clear_all) begin
      v_q <= '0;
    end else if (st_write) begin
      v_q[st_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_write) begin
      tag_q[st_idx]  <= st_tag;
      mask_q[st_idx] <= (st_hit ? mask_q[st_idx] : '0) | st_mask;
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (st_mask[b]) data_q[st_idx][b*8 +: 8] <= st_data[b*8 +: 8];
      end
    end
  end

  // load lookup with byte merge, one cycle response
  logic                  ld_fire;
  logic [IDX_W-1:0]      ld_idx;
  logic [LINE_BYTES-1:0] ld_cov;
  logic [DW-1:0]         ld_merged;
  assign ld_ready = !busy;
  assign ld_fire  = ld_valid && ld_ready;
  assign ld_idx   = {ld_set, ld_hit_way};
  assign ld_cov   = ld_hit ? mask_q[ld_idx] : '0;

  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      ld_merged[b*8 +: 8] = ld_cov[b] ? data_q[ld_idx][b*8 +: 8]
                                      : ld_mem_data[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_rsp_valid <= 1'b0;
      ld_rsp_data  <= '0;
      ld_rsp_full  <= 1'b0;
    end else begin
      ld_rsp_valid <= ld_fire;
      if (ld_fire) begin
        ld_rsp_data <= ld_merged;
        ld_rsp_full <= (ld_cov & ld_mask) == ld_mask;
      end
    end
  end

  // drain port
  assign publish  = busy;
  assign dr_valid = busy && v_q[ptr];
  assign dr_line  = {tag_q[ptr], ptr[IDX_W-1:WAY_W]};
  assign dr_data  = data_q[ptr];
  assign dr_mask  = mask_q[ptr];
endmodule

// File: rtl/stratum_wcache_chk.sv
module stratum_wcache_chk #(
  parameter int unsigned LINE_AW    = 26,
  parameter int unsigned LINE_BYTES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_bounded,
  input logic                  st_ready,
  input logic                  ld_valid,
  input logic                  ld_ready,
  input logic                  ld_rsp_valid,
  input logic                  dr_valid,
  input logic                  dr_ready,
  input logic [LINE_AW-1:0]    dr_line,
  input logic [LINE_BYTES*8-1:0] dr_data,
  input logic [LINE_BYTES-1:0] dr_mask,
  input logic                  log_valid,
  input logic                  publish,
  input logic                  flush_done,
  input logic                  overflow_req
);
  assert_pub_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    publish |-> (!st_ready && !ld_ready));

  assert_drain_in_pub_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> publish);

  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=>
      (dr_valid && $stable(dr_line) && $stable(dr_data) && $stable(dr_mask)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(publish) |-> flush_done);

  assert_ld_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rsp_valid |-> $past(ld_valid && ld_ready));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_req |-> (mode_bounded && !st_ready && !log_valid));

  assert_log_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> (!mode_bounded && !overflow_req));
endmodule

bind stratum_wcache stratum_wcache_chk #(.LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_bounded(mode_bounded), .st_ready(st_ready),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_rsp_valid(ld_rsp_valid),
  .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_line(dr_line),
  .dr_data(dr_data), .dr_mask(dr_mask), .log_valid(log_valid),
  .publish(publish), .flush_done(flush_done), .overflow_req(overflow_req)
);

// File: tb/stratum_wcache_bench.sv
module stratum_wcache_bench;
  localparam int ENT = 16, WY = 4, LB = 4, AW = 6, NS = ENT / WY, DW = LB * 8;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic mode_bounded = 1, flush_start = 0;
  logic st_valid = 0, ld_valid = 0, dr_ready = 0, log_ready = 0;
  logic [AW-1:0] st_line = 0, ld_line = 0;
  logic [DW-1:0] st_data = 0, ld_mem_data = 0;
  logic [LB-1:0] st_mask = 0, ld_mask = 0;
  logic st_ready, ld_ready, ld_rsp_valid, ld_rsp_full, dr_valid, log_valid;
  logic publish, flush_done, overflow_req;
  logic [DW-1:0] ld_rsp_data, dr_data, log_data;
  logic [AW-1:0] dr_line, log_line;
  logic [LB-1:0] dr_mask, log_mask;

  stratum_wcache #(.ENTRIES(ENT), .WAYS(WY), .LINE_BYTES(LB), .LINE_AW(AW)) u_stratum_wcache (.*);

  int errors = 0, checks = 0;
  // reference contents, index = set*WY + way
  bit            mv [ENT];
  logic [AW-1:0] ml [ENT];
  logic [DW-1:0] md [ENT];
  logic [LB-1:0] mm [ENT];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int line, input int rnd);
    logic [DW-1:0] d;
    for (int b = 0; b < LB; b++) d[b*8 +: 8] = 8'(line * 7 + b * 29 + rnd * 53 + 1);
    return d;
  endfunction

  function automatic int find(input logic [AW-1:0] line);
    for (int i = 0; i < ENT; i++) if (mv[i] && ml[i] == line) return i;
    return -1;
  endfunction

  function automatic void model_store(input logic [AW-1:0] line, input logic [DW-1:0] d,
                                      input logic [LB-1:0] m);
    int i = find(line);
    if (i < 0) begin
      for (int w = WY - 1; w >= 0; w--) if (!mv[int'(line[1:0]) * WY + w]) i = int'(line[1:0]) * WY + w;
      mv[i] = 1; ml[i] = line; mm[i] = 0;
    end
    mm[i] = mm[i] | m;
    for (int b = 0; b < LB; b++) if (m[b]) md[i][b*8 +: 8] = d[b*8 +: 8];
  endfunction

  task automatic store(input logic [AW-1:0] line, input int rnd, input logic [LB-1:0] m);
    st_valid = 1; st_line = line; st_data = pat(line, rnd); st_mask = m;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 0;
    model_store(line, pat(line, rnd), m);
  endtask

  task automatic load(input logic [AW-1:0] line, input logic [LB-1:0] lm, input string req);
    logic [DW-1:0] mem, exp;
    logic [LB-1:0] cov;
    int i;
    mem = pat(line, 9) ^ 32'hA5A5A5A5;
    ld_valid = 1; ld_line = line; ld_mask = lm; ld_mem_data = mem;
    while (!ld_ready) @(negedge clk);
    @(negedge clk);
    ld_valid = 0;
    i = find(line);
    cov = (i >= 0) ? mm[i] : '0;
    for (int b = 0; b < LB; b++) exp[b*8 +: 8] = cov[b] ? md[i][b*8 +: 8] : mem[b*8 +: 8];
    chk(ld_rsp_valid == 1, req, "ld_rsp_valid", 64'(ld_rsp_valid), 1);
    chk(ld_rsp_data == exp, req, "ld_rsp_data", 64'(ld_rsp_data), 64'(exp));
    chk(ld_rsp_full == ((cov & lm) == lm), req, "ld_rsp_full", 64'(ld_rsp_full),
        64'((cov & lm) == lm));
  endtask

  task automatic flush(input bit inject, output int pub_cycles);
    int beats = 0, k = 0, nexp = 0;
    for (int i = 0; i < ENT; i++) nexp += int'(mv[i]);
    pub_cycles = 0;
    flush_start = 1;
    @(negedge clk);
    flush_start = 0;
    chk(publish == 1, "R6", "publish after flush_start", 64'(publish), 1);
    chk(!st_ready && !ld_ready, "R5", "ready during publish", 64'({st_ready, ld_ready}), 0);
    for (int g = 0; g < 400; g++) begin
      if (flush_done) break;
      pub_cycles++;
      flush_start = inject && (pub_cycles == 3);
      dr_ready = (g % 3) != 1;
      if (dr_valid && dr_ready) begin
        while (k < ENT && !mv[k]) k++;
        if (k < ENT) begin
          chk(dr_line == ml[k], "R2", "drain line order", 64'(dr_line), 64'(ml[k]));
          chk(dr_data == md[k], "R3", "drain data", 64'(dr_data), 64'(md[k]));
          chk(dr_mask == mm[k], "R3", "drain mask", 64'(dr_mask), 64'(mm[k]));
        end
        k++; beats++;
      end
      @(negedge clk);
    end
    flush_start = 0; dr_ready = 0;
    chk(flush_done && !publish, "R7", "done with publish low", 64'({flush_done, publish}), 2);
    chk(beats == nexp, "R6", "drain beat count", 64'(beats), 64'(nexp));
    @(negedge clk);
    chk(!flush_done && !publish, "R10", "no second flush / done pulse",
        64'({flush_done, publish}), 0);
    for (int i = 0; i < ENT; i++) mv[i] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pc;
    for (int i = 0; i < ENT; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!publish && !flush_done && !overflow_req && !log_valid && !dr_valid, "R1",
        "idle outputs", 64'({publish, flush_done, overflow_req, log_valid, dr_valid}), 0);
    chk(st_ready && ld_ready, "R1", "ready after reset", 64'({st_ready, ld_ready}), 3);
    // R11 empty flush length
    flush(0, pc);
    chk(pc == ENT, "R11", "publish cycles on empty flush", 64'(pc), 64'(ENT));

    // R2 allocation: three lines per set with distinct masks
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 3; k++)
        store(AW'((k + 1) * NS + s), 0, (k == 0) ? 4'b0011 : (k == 1) ? 4'b1100 : 4'b0101);
    // R3 merge with an overlapping mask
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 3; k++)
        store(AW'((k + 1) * NS + s), 1, 4'b0110);
    // R4 loads over held and absent lines
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++) begin
        load(AW'((k + 1) * NS + s), 4'b1111, "R4");
        load(AW'((k + 1) * NS + s), 4'b0110, "R4");
        load(AW'((k + 1) * NS + s), 4'b0010, "R4");
      end
    // R6/R10 flush with stalls and a stray flush command
    flush(1, pc);
    // R7 buffer empty afterwards
    flush(0, pc);
    chk(pc == ENT, "R7", "second flush length", 64'(pc), 64'(ENT));

    // R8 bounded overflow on set 2
    mode_bounded = 1;
    for (int t = 1; t <= 4; t++) store(AW'(t * NS + 2), 2, 4'b1111);
    st_valid = 1; st_line = AW'(5 * NS + 2); st_data = pat(5 * NS + 2, 3); st_mask = 4'b1111;
    repeat (2) @(negedge clk);
    chk(!st_ready && overflow_req && !log_valid, "R8", "held store",
        64'({st_ready, overflow_req, log_valid}), 64'(3'b010));
    st_valid = 0;
    @(negedge clk);
    load(AW'(5 * NS + 2), 4'b1111, "R8");
    flush(0, pc);
    store(AW'(5 * NS + 2), 3, 4'b1111);
    load(AW'(5 * NS + 2), 4'b1111, "R8");

    // R9 unbounded: spill to log on set 1
    mode_bounded = 0;
    for (int t = 1; t <= 4; t++) store(AW'(t * NS + 1), 4, 4'b1001);
    st_valid = 1; st_line = AW'(6 * NS + 1); st_data = pat(6 * NS + 1, 5); st_mask = 4'b0111;
    log_ready = 0;
    @(negedge clk);
    chk(log_valid && !st_ready && !overflow_req, "R9", "log offered, not taken",
        64'({log_valid, st_ready, overflow_req}), 64'(3'b100));
    log_ready = 1;
    #1;
    chk(st_ready == 1, "R9", "st_ready with log_ready", 64'(st_ready), 1);
    chk(log_line == AW'(6 * NS + 1) && log_data == pat(6 * NS + 1, 5) && log_mask == 4'b0111,
        "R9", "log record", 64'({log_line, log_mask}), 64'({AW'(6 * NS + 1), 4'b0111}));
    @(negedge clk);
    st_valid = 0; log_ready = 0;
    load(AW'(6 * NS + 1), 4'b0111, "R9");
    flush(0, pc);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule